// File: doc/BRIEF.md
# Wormhole Router Input Stage

This block is the receiving front end of one port of a mesh switch that moves packets by wormhole routing. In every cycle it may take one flit, either from the neighbouring switch or from the local host, into a single-flit holding register. When that flit is a packet header, the stage works out the next hop by dimension-ordered routing, X before Y. It then either ejects the flit to the local host or pushes it into the FIFO of one of four network directions. The FIFOs, the crossbar behind them and output arbitration belong to later pipeline stages that share the same clock.

The neighbour link always takes precedence, and the host injects only into idle slots. Once a header has left, its direction is kept in a route register. Every later body or tail flit of that packet follows it without any new decode, and the tail releases the route. While one source has a packet open, the other source is held off, so two packets never share the route register. If the FIFO chosen by the current flit is full, the stage keeps its register and holds both sources not-ready. A source that is not served keeps its flit under a valid/ready handshake and loses nothing.

Top module: `ws_input_stage`

## Requirements
- R1: When no packet is open and `netValid` is high, `hostReady` is low. A host flit is accepted only in a cycle where `netValid` is low or a host packet is open.
- R2: A packet opens when its header is accepted and closes when its tail is accepted. While it is open, the ready of the other source stays low.
- R3: A flit accepted at a clock edge appears on `outFlit` in the following cycle, with exactly one push strobe. Both readys can be high only while the register is empty or being emptied that cycle.
- R4: The flit type is taken from flit bits [FLIT_W-1:FLIT_W-2] (00 idle, 01 header, 10 body, 11 tail). For a header, destination X is bits [2*COORD_W-1:COORD_W]. If X is greater than `myX` the header goes East (`outPush[0]`), and if it is smaller it goes West (`outPush[1]`).
- R5: If the header's X equals `myX`, destination Y (bits [COORD_W-1:0]) is compared with `myY`. A greater Y goes North (`outPush[2]`) and a smaller Y goes South (`outPush[3]`).
- R6: A header whose X and Y both match the local coordinates goes to the host through `ejPush`.
- R7: Body and tail flits go wherever their packet's header went, whatever their payload bits hold. The route is released when the tail leaves.
- R8: A body or tail flit that arrives with no open route is discarded: no push is made and the stage stays ready.
- R9: Idle-type flits are consumed and discarded. They never reach the register and produce no push.
- R10: If the FIFO selected for the current flit is full (`outFull[d]`, or `ejFull` for ejection), nothing is pushed. The register holds its flit and both readys are low until space appears.
- R11: At most one of `outPush[3:0]` and `ejPush` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global pipeline clock |
| rstN | input | 1 | Active-low synchronous reset |
| myX | input | COORD_W | X coordinate of this switch |
| myY | input | COORD_W | Y coordinate of this switch |
| netValid | input | 1 | Neighbour flit offered |
| netFlit | input | FLIT_W | Neighbour flit |
| netReady | output | 1 | Neighbour flit taken this cycle when valid |
| hostValid | input | 1 | Host injection flit offered |
| hostFlit | input | FLIT_W | Host injection flit |
| hostReady | output | 1 | Host flit taken this cycle when valid |
| outFull | input | 4 | Full flags of the East, West, North and South FIFOs |
| ejFull | input | 1 | Host ejection path full |
| outPush | output | 4 | Push strobes into the East, West, North and South FIFOs |
| ejPush | output | 1 | Push strobe toward the local host |
| outFlit | output | FLIT_W | Flit being pushed |

## Verification
The bench builds the stage with COORD_W=2 and FLIT_W=8, which leaves sixteen switch positions and sixteen destinations. At that size the bench can sweep every pairing of switch position and header destination and compute the expected direction arithmetically for each one. That sweep covers every East/West/North/South/eject outcome, including the edge and corner positions of the mesh. The small size also keeps each directed sequence short: priority collisions, cross-source locking, stalls on a full FIFO, stray and idle flits.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flit_type_e;

  typedef enum logic [2:0] {
    DIR_EAST  = 3'd0,
    DIR_WEST  = 3'd1,
    DIR_NORTH = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_LOCAL = 3'd4
  } dir_e;

  localparam int NUM_DIRS = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReg;     // capture the selected flit
    logic takeHost;    // selected flit comes from the host
    logic latchRoute;  // header leaving: keep its direction
    logic clearRoute;  // tail leaving: release the route
  } strobe_s;

endpackage

// File: rtl/ws_route_calc.sv
module ws_route_calc
  import ws_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  output dir_e               dir
);

  // X dimension is resolved fully before Y is looked at
  always_comb begin
    if (dstX > myX)      dir = DIR_EAST;
    else if (dstX < myX) dir = DIR_WEST;
    else if (dstY > myY) dir = DIR_NORTH;
    else if (dstY < myY) dir = DIR_SOUTH;
    else                 dir = DIR_LOCAL;
  end

endmodule

// File: rtl/ws_in_datapath.sv
module ws_in_datapath
  import ws_pkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_s           strb,
  input  logic [FLIT_W-1:0] netFlit,
  input  logic [FLIT_W-1:0] hostFlit,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  output logic [FLIT_W-1:0] regFlit,
  output flit_type_e        regType,
  output dir_e              curDir,
  output logic              routeOpen
);

  localparam int TYPE_MSB = FLIT_W - 1;
  localparam int X_LSB    = COORD_W;
  localparam int X_MSB    = 2 * COORD_W - 1;

  logic [FLIT_W-1:0] flitReg;
  dir_e              routeReg;
  logic              openReg;
  dir_e              headDir;

  ws_route_calc #(.COORD_W(COORD_W)) uCalc (
    .myX  (myX),
    .myY  (myY),
    .dstX (flitReg[X_MSB:X_LSB]),
    .dstY (flitReg[COORD_W-1:0]),
    .dir  (headDir)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flitReg  <= '0;
      routeReg <= DIR_LOCAL;
      openReg  <= 1'b0;
    end else begin
      if (strb.loadReg)
        flitReg <= strb.takeHost ? hostFlit : netFlit;
      if (strb.latchRoute) begin
        routeReg <= headDir;
        openReg  <= 1'b1;
      end else if (strb.clearRoute) begin
        openReg  <= 1'b0;
      end
    end
  end

  assign regFlit   = flitReg;
  assign regType   = flit_type_e'(flitReg[TYPE_MSB -: 2]);
  assign curDir    = (regType == FT_HEAD) ? headDir : routeReg;
  assign routeOpen = openReg;

endmodule

// File: rtl/ws_in_control.sv
module ws_in_control
  import ws_pkg::*;
#(
  parameter int N_OUT = NUM_DIRS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             netValid,
  input  logic             hostValid,
  input  flit_type_e       netType,
  input  flit_type_e       hostType,
  input  flit_type_e       regType,
  input  dir_e             curDir,
  input  logic             routeOpen,
  input  logic [N_OUT-1:0] outFull,
  input  logic             ejFull,
  output logic             netReady,
  output logic             hostReady,
  output logic [N_OUT-1:0] outPush,
  output logic             ejPush,
  output strobe_s          strb
);

  logic       regValid;
  logic       pktOpen;
  logic       pktHost;
  logic       haveRoute;
  logic       tgtFull;
  logic       fire;
  logic       drop;
  logic       inReady;
  logic       takeNet;
  logic       takeHost;
  flit_type_e selType;

  always_comb begin
    haveRoute = (regType == FT_HEAD) || routeOpen;

    tgtFull = 1'b0;
    if (curDir == DIR_LOCAL) tgtFull = ejFull;
    else begin
      for (int d = 0; d < N_OUT; d++)
        if (int'(curDir) == d) tgtFull = outFull[d];
    end

    fire    = regValid && haveRoute && !tgtFull;
    drop    = regValid && !haveRoute;
    inReady = !regValid || fire || drop;

    // neighbour first; an open packet locks out the other source
    netReady  = inReady && (!pktOpen || !pktHost);
    hostReady = inReady && (pktOpen ? pktHost : !netValid);

    takeNet  = netValid && netReady;
    takeHost = hostValid && hostReady && !takeNet;
    selType  = takeNet ? netType : hostType;

    strb.loadReg    = (takeNet || takeHost) && (selType != FT_IDLE);
    strb.takeHost   = takeHost;
    strb.latchRoute = fire && (regType == FT_HEAD);
    strb.clearRoute = fire && (regType == FT_TAIL);

    ejPush = fire && (curDir == DIR_LOCAL);
    for (int d = 0; d < N_OUT; d++)
      outPush[d] = fire && (int'(curDir) == d);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regValid <= 1'b0;
      pktOpen  <= 1'b0;
      pktHost  <= 1'b0;
    end else begin
      if (strb.loadReg)       regValid <= 1'b1;
      else if (fire || drop)  regValid <= 1'b0;

      if (strb.loadReg) begin
        if (selType == FT_HEAD) begin
          pktOpen <= 1'b1;
          pktHost <= takeHost;
        end else if (selType == FT_TAIL) begin
          pktOpen <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/ws_input_stage.sv
module ws_input_stage
  import ws_pkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic               netValid,
  input  logic [FLIT_W-1:0]  netFlit,
  output logic               netReady,
  input  logic               hostValid,
  input  logic [FLIT_W-1:0]  hostFlit,
  output logic               hostReady,
  input  logic [3:0]         outFull,
  input  logic               ejFull,
  output logic [3:0]         outPush,
  output logic               ejPush,
  output logic [FLIT_W-1:0]  outFlit
);

  localparam int TYPE_MSB = FLIT_W - 1;

  strobe_s    strb;
  flit_type_e regType;
  dir_e       curDir;
  logic       routeOpen;

  ws_in_control #(.N_OUT(NUM_DIRS)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .netValid  (netValid),
    .hostValid (hostValid),
    .netType   (flit_type_e'(netFlit[TYPE_MSB -: 2])),
    .hostType  (flit_type_e'(hostFlit[TYPE_MSB -: 2])),
    .regType   (regType),
    .curDir    (curDir),
    .routeOpen (routeOpen),
    .outFull   (outFull),
    .ejFull    (ejFull),
    .netReady  (netReady),
    .hostReady (hostReady),
    .outPush   (outPush),
    .ejPush    (ejPush),
    .strb      (strb)
  );

  ws_in_datapath #(.FLIT_W(FLIT_W), .COORD_W(COORD_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .netFlit   (netFlit),
    .hostFlit  (hostFlit),
    .myX       (myX),
    .myY       (myY),
    .regFlit   (outFlit),
    .regType   (regType),
    .curDir    (curDir),
    .routeOpen (routeOpen)
  );

endmodule

// File: rtl/ws_input_stage_chk.sv
module ws_input_stage_chk #(
  parameter int FLIT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              netValid,
  input logic [FLIT_W-1:0] netFlit,
  input logic              netReady,
  input logic              hostValid,
  input logic [FLIT_W-1:0] hostFlit,
  input logic              hostReady,
  input logic [3:0]        outFull,
  input logic              ejFull,
  input logic [3:0]        outPush,
  input logic              ejPush
);

  AST_NET_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    !(netValid && netReady && hostReady)); // R1

  AST_HOST_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && hostFlit[FLIT_W-1 -: 2] == 2'b01) |=> !netReady); // R2

  AST_HEAD_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (netValid && netReady && netFlit[FLIT_W-1 -: 2] == 2'b01)
      |=> ((|outPush) || ejPush || (!netReady && !hostReady))); // R3

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !((|(outPush & outFull)) || (ejPush && ejFull))); // R10

  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ejPush, outPush})); // R11

endmodule

bind ws_input_stage ws_input_stage_chk #(.FLIT_W(FLIT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .netValid  (netValid),
  .netFlit   (netFlit),
  .netReady  (netReady),
  .hostValid (hostValid),
  .hostFlit  (hostFlit),
  .hostReady (hostReady),
  .outFull   (outFull),
  .ejFull    (ejFull),
  .outPush   (outPush),
  .ejPush    (ejPush)
);

// File: tb/tb_ws_input_stage.sv
module tb_ws_input_stage;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 8;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] myX = '0, myY = '0;
  logic          netValid = 1'b0, hostValid = 1'b0;
  logic [FW-1:0] netFlit = '0, hostFlit = '0;
  logic          netReady, hostReady;
  logic [3:0]    outFull = '0;
  logic          ejFull = 1'b0;
  logic [3:0]    outPush;
  logic          ejPush;
  logic [FW-1:0] outFlit;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ws_input_stage #(.FLIT_W(FW), .COORD_W(CW)) dut (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY),
    .netValid(netValid), .netFlit(netFlit), .netReady(netReady),
    .hostValid(hostValid), .hostFlit(hostFlit), .hostReady(hostReady),
    .outFull(outFull), .ejFull(ejFull),
    .outPush(outPush), .ejPush(ejPush), .outFlit(outFlit)
  );

  // push code: 1 East, 2 West, 4 North, 8 South, 16 eject
  function automatic int mk(input int t, input int x, input int y);
    return ((t & 3) << 6) | ((x & 3) << 2) | (y & 3);
  endfunction

  function automatic int expDir(input int mx, input int my, input int dx, input int dy);
    if (dx > mx) return 1;
    if (dx < mx) return 2;
    if (dy > my) return 4;
    if (dy < my) return 8;
    return 16;
  endfunction

  function automatic int pushes();
    return {27'd0, ejPush, outPush};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offer one neighbour flit for one edge, then sample the push
  task automatic netOne(input int f, input int expPush, input string req);
    @(negedge clk);
    netValid = 1'b1;
    netFlit  = FW'(f);
    @(negedge clk);
    netValid = 1'b0;
    chk(req, pushes(), expPush);
    if (expPush != 0) chk(req, int'(outFlit), f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3: empty register after reset
    chk("R3 reset push", pushes(), 0);
    chk("R3 reset netReady", int'(netReady), 1);
    chk("R3 reset hostReady", int'(hostReady), 1);

    // R4 R5 R6 R7: every switch position against every destination
    for (int mx = 0; mx < 4; mx++)
      for (int my = 0; my < 4; my++)
        for (int dx = 0; dx < 4; dx++)
          for (int dy = 0; dy < 4; dy++) begin
            string req;
            int e;
            myX = CW'(mx);
            myY = CW'(my);
            e = expDir(mx, my, dx, dy);
            req = (dx != mx) ? "R4" : ((dy != my) ? "R5" : "R6");
            netOne(mk(1, dx, dy), e, req);
            netOne(mk(3, 3 - dx, 3 - dy), e, "R7 tail");
          end

    // R7 body misleading payload, R8 stray body after tail
    myX = 2'd1; myY = 2'd1;
    netOne(mk(1, 3, 1), 1, "R7 head");
    netOne(mk(2, 0, 0), 1, "R7 body");
    netOne(mk(3, 1, 3), 1, "R7 tail");
    netOne(mk(2, 0, 0), 0, "R8 stray body");
    chk("R8 ready", int'(netReady), 1);
    netOne(mk(3, 2, 2), 0, "R8 stray tail");
    // R9 idle flit
    netOne(mk(0, 3, 3), 0, "R9 idle");
    netOne(mk(1, 1, 0), 8, "R9 next head");
    netOne(mk(3, 0, 0), 8, "R9 next tail");

    // R1 and R2: collision and locking
    @(negedge clk);
    netValid = 1'b1; netFlit = FW'(mk(1, 0, 1));
    hostValid = 1'b1; hostFlit = FW'(mk(1, 1, 2));
    #1;
    chk("R1 hostReady low", int'(hostReady), 0);
    chk("R1 netReady high", int'(netReady), 1);
    @(negedge clk);
    chk("R1 net head first", pushes(), 2);
    chk("R1 net flit", int'(outFlit), mk(1, 0, 1));
    netValid = 1'b0;
    #1;
    chk("R2 host locked out", int'(hostReady), 0);
    netValid = 1'b1; netFlit = FW'(mk(3, 0, 0));
    @(negedge clk);
    chk("R2 net tail", pushes(), 2);
    netValid = 1'b0;
    #1;
    chk("R1 host granted", int'(hostReady), 1);
    @(negedge clk);
    chk("R1 host head", pushes(), 4);
    chk("R1 host flit", int'(outFlit), mk(1, 1, 2));
    netValid = 1'b1; netFlit = FW'(mk(1, 3, 1));
    hostFlit = FW'(mk(3, 0, 0));
    #1;
    chk("R2 net locked out", int'(netReady), 0);
    @(negedge clk);
    chk("R2 host tail", pushes(), 4);
    chk("R2 host tail flit", int'(outFlit), mk(3, 0, 0));
    hostValid = 1'b0;
    @(negedge clk);
    chk("R2 net head after", pushes(), 1);
    netFlit = FW'(mk(3, 0, 0));
    @(negedge clk);
    netValid = 1'b0;
    chk("R2 net tail after", pushes(), 1);
    @(negedge clk);
    chk("R3 no repeat push", pushes(), 0);

    // R10 stall on full East FIFO
    outFull = 4'b0001;
    @(negedge clk);
    netValid = 1'b1; netFlit = FW'(mk(1, 2, 0));
    @(negedge clk);
    netValid = 1'b0;
    hostValid = 1'b1; hostFlit = FW'(mk(1, 0, 0));
    for (int i = 0; i < 3; i++) begin
      chk("R10 no push", pushes(), 0);
      chk("R10 netReady", int'(netReady), 0);
      chk("R10 hostReady", int'(hostReady), 0);
      chk("R10 held flit", int'(outFlit), mk(1, 2, 0));
      @(negedge clk);
    end
    hostValid = 1'b0;
    outFull = 4'b0000;
    #1;
    chk("R10 release push", pushes(), 1);
    @(negedge clk);
    chk("R10 single push", pushes(), 0);
    netOne(mk(3, 0, 0), 1, "R10 tail");

    // R10 stall on ejection
    ejFull = 1'b1;
    netOne(mk(1, 1, 1), 0, "R10 eject held");
    chk("R10 eject netReady", int'(netReady), 0);
    @(negedge clk);
    ejFull = 1'b0;
    #1;
    chk("R6 eject release", pushes(), 16);
    netOne(mk(3, 0, 0), 16, "R6 eject tail");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule